// File: doc/BRIEF.md
# Dual-Port RAM Access Arbiter

This block shares one RAM controller between the local processor and an outside bus master that reaches the RAM as a slave. The outside request and its read or write command arrive with no fixed relation to the local clock, so they are synchronized first. A slave cycle then moves through fixed clocked phases. A sync flag sets. Slave mode is entered, which commits the cycle. The off-board chip select goes active one clock later, and after that the slave strobe is passed to the controller. The controller's transfer acknowledge is returned to the bus master. When the master drops its command, the cycle releases in three staggered steps.

The local processor has priority. A processor request that arrives before the slave cycle commits cancels that cycle, and the processor strobe goes straight to the controller. A processor request that arrives after the commit waits until the chip select drops. A slave request that is still pending when the processor finishes starts again by itself. All outputs are registered and active-low.

Top module: `dpRamArbiter`

## Requirements
- R1: While reset is held and right after it, slaveModeN, offBdCsN, ramRdN, ramWrN and slvXackN are all high.
- R2: With the default two synchronizer stages, slave request and command inputs (all active-low) that go low before a clock edge make slaveModeN go low at the fourth rising edge after that, provided no processor request is present.
- R3: offBdCsN goes low one clock after slaveModeN. The slave strobe reaches the controller one clock after that: on ramRdN for a read (slvRdN) and on ramWrN for a write (slvWrN).
- R4: The sync flag clears on the clock after the controller's address acknowledge (ramAackN low) is sampled during a committed cycle.
- R5: While the chip select is active, slvXackN follows ramXackN low through one register. It returns high one clock after ramXackN returns high.
- R6: When the slave command goes high, release is staggered. The synchronized command drop reaches the RAM strobe at the third edge. slaveModeN goes high at the fourth edge and offBdCsN at the fifth.
- R7: A processor request (cpuReqN low) that arrives after slave mode is entered does not abort the cycle. Its strobe reaches the controller one clock after offBdCsN goes high.
- R8: A processor request that arrives while the sync flag is set, but before slave mode, aborts the slave cycle. slaveModeN stays high, and the processor strobe (cpuRdN on ramRdN, cpuWrN on ramWrN) appears at the next edge.
- R9: When processor and slave requests are present in the same cycle, the processor wins. slaveModeN stays high while the processor request lasts.
- R10: When the processor request ends and a slave request is still pending, the sync flag sets at the next edge and slaveModeN goes low at the second edge.
- R11: The transfer acknowledge has no effect on a processor access. slvXackN stays high even when ramXackN is low during the processor access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Synchronous active-low reset |
| slvReqN | input | 1 | Outside slave request, asynchronous, active-low |
| slvRdN | input | 1 | Outside slave read command, asynchronous, active-low |
| slvWrN | input | 1 | Outside slave write command, asynchronous, active-low |
| cpuReqN | input | 1 | Local processor RAM request, active-low |
| cpuRdN | input | 1 | Local processor read strobe, active-low |
| cpuWrN | input | 1 | Local processor write strobe, active-low |
| ramAackN | input | 1 | Controller address acknowledge, active-low |
| ramXackN | input | 1 | Controller transfer acknowledge, active-low |
| slaveModeN | output | 1 | Slave mode (committed slave cycle), active-low |
| offBdCsN | output | 1 | Off-board chip select to the controller, active-low |
| ramRdN | output | 1 | Read strobe to the controller, active-low |
| ramWrN | output | 1 | Write strobe to the controller, active-low |
| slvXackN | output | 1 | Transfer acknowledge to the outside master, active-low |

## Verification
The hardest case is the narrow window of a single clock between the sync flag setting and slave mode being entered. Only a processor request landing exactly there shows the abort path. The bench counts edges from the moment it drives the slave inputs and places the processor request on the third edge. It does this for every combination of slave read/write and processor read/write. The same sweep also places the processor request one edge later, which is past the commit, and in the same cycle as the slave request. Each outcome is told apart by whether slave mode appears and when the processor strobe does.

// File: rtl/dpArbPkg.sv
package dpArbPkg;
  // Strobes passed from the sequencing control to the datapath
  typedef struct packed {
    logic slaveMode;
    logic chipSel;
    logic cpuGrant;
  } arbStrobes_t;

  localparam int unsigned SLV_REQ = 2;
  localparam int unsigned SLV_RD  = 1;
  localparam int unsigned SLV_WR  = 0;
endpackage

// File: rtl/syncChain.sv
module syncChain #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) stage[0] <= '0;
          else       stage[0] <= dIn;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign dOut = stage[STAGES-1];
endmodule

// File: rtl/dpArbCtrl.sv
module dpArbCtrl
  import dpArbPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        slvReq,
  input  logic        slvRd,
  input  logic        slvWr,
  input  logic        cpuReq,
  input  logic        ramAack,
  output arbStrobes_t strobes
);
  logic syncFlag;
  logic lockEn;
  logic slaveMode;
  logic chipSel;
  logic slvCmd;

  assign slvCmd = slvRd | slvWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncFlag  <= 1'b0;
      lockEn    <= 1'b1;
      slaveMode <= 1'b0;
      chipSel   <= 1'b0;
    end else begin
      // sync flag and lock enable
      if (!syncFlag && !slaveMode && !chipSel && lockEn && slvReq && slvCmd && !cpuReq) begin
        syncFlag <= 1'b1;
        lockEn   <= 1'b0;
      end else if (syncFlag && !slaveMode && (cpuReq || !slvCmd)) begin
        syncFlag <= 1'b0;   // abort before commit
        lockEn   <= 1'b1;
      end else if (syncFlag && slaveMode && ramAack) begin
        syncFlag <= 1'b0;
      end
      // release step one: lock enable returns
      if (slaveMode && !lockEn && !slvCmd) begin
        lockEn   <= 1'b1;
        syncFlag <= 1'b0;
      end
      // slave mode: commit, then release step two
      if (syncFlag && !slaveMode && !cpuReq && slvCmd) slaveMode <= 1'b1;
      else if (slaveMode && lockEn)                    slaveMode <= 1'b0;
      // chip select: after commit, release step three
      if (slaveMode && !chipSel && !lockEn) chipSel <= 1'b1;
      else if (chipSel && !slaveMode)       chipSel <= 1'b0;
    end
  end

  assign strobes.slaveMode = slaveMode;
  assign strobes.chipSel   = chipSel;
  assign strobes.cpuGrant  = cpuReq && !slaveMode && !chipSel;

  // R7: once committed, a processor request cannot remove slave mode
  a_r7_commit_holds: assert property (@(posedge clk) disable iff (!rstN)
    (slaveMode && !lockEn && slvCmd && cpuReq) |=> slaveMode);
  // R3: chip select only rises while slave mode has been held
  a_r3_cs_after_mode: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chipSel) |-> (slaveMode && $past(slaveMode)));
  // R6: slave mode falls only after lock enable returned, chip select still up
  a_r6_release_order: assert property (@(posedge clk) disable iff (!rstN)
    $fell(slaveMode) |-> ($past(lockEn) && chipSel));
  // R4: address acknowledge clears the sync flag on the next clock
  a_r4_sync_clears: assert property (@(posedge clk) disable iff (!rstN)
    (syncFlag && slaveMode && ramAack) |=> !syncFlag);
  // R8: processor request before commit aborts the slave cycle
  a_r8_abort: assert property (@(posedge clk) disable iff (!rstN)
    (syncFlag && !slaveMode && cpuReq) |=> (!syncFlag && !slaveMode));
  // R9: no slave cycle starts while the processor requests
  a_r9_cpu_first: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !syncFlag && !slaveMode) |=> !syncFlag);
endmodule

// File: rtl/dpArbData.sv
module dpArbData
  import dpArbPkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        slvReqN,
  input  logic        slvRdN,
  input  logic        slvWrN,
  input  logic        cpuRdN,
  input  logic        cpuWrN,
  input  logic        ramXackN,
  input  arbStrobes_t strobes,
  output logic        slvReqS,
  output logic        slvRdS,
  output logic        slvWrS,
  output logic        ramRdN,
  output logic        ramWrN,
  output logic        slvXackN
);
  localparam int unsigned SYNC_W = 3;

  logic [SYNC_W-1:0] slvS;
  logic ramRdQ, ramWrQ, xackQ;

  syncChain #(.STAGES(SYNC_STAGES), .WIDTH(SYNC_W)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  ({~slvReqN, ~slvRdN, ~slvWrN}),
    .dOut (slvS)
  );

  assign slvReqS = slvS[SLV_REQ];
  assign slvRdS  = slvS[SLV_RD];
  assign slvWrS  = slvS[SLV_WR];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ramRdQ <= 1'b0;
      ramWrQ <= 1'b0;
      xackQ  <= 1'b0;
    end else begin
      ramRdQ <= (strobes.cpuGrant && !cpuRdN) || (strobes.chipSel && slvRdS);
      ramWrQ <= (strobes.cpuGrant && !cpuWrN) || (strobes.chipSel && slvWrS);
      xackQ  <= strobes.chipSel && !ramXackN;
    end
  end

  assign ramRdN   = ~ramRdQ;
  assign ramWrN   = ~ramWrQ;
  assign slvXackN = ~xackQ;

  // R11: acknowledge to the outside master never appears without chip select
  a_r11_xack_gated: assert property (@(posedge clk) disable iff (!rstN)
    !xackQ || $past(strobes.chipSel));
  // R3: a slave strobe reaches the controller only through the chip select
  a_r3_slave_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramRdQ || ramWrQ) |-> ($past(strobes.chipSel) || $past(strobes.cpuGrant)));
endmodule

// File: rtl/dpRamArbiter.sv
module dpRamArbiter
  import dpArbPkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic slvReqN,
  input  logic slvRdN,
  input  logic slvWrN,
  input  logic cpuReqN,
  input  logic cpuRdN,
  input  logic cpuWrN,
  input  logic ramAackN,
  input  logic ramXackN,
  output logic slaveModeN,
  output logic offBdCsN,
  output logic ramRdN,
  output logic ramWrN,
  output logic slvXackN
);
  arbStrobes_t strobes;
  logic slvReqS, slvRdS, slvWrS;

  dpArbData #(.SYNC_STAGES(SYNC_STAGES)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .slvReqN  (slvReqN),
    .slvRdN   (slvRdN),
    .slvWrN   (slvWrN),
    .cpuRdN   (cpuRdN),
    .cpuWrN   (cpuWrN),
    .ramXackN (ramXackN),
    .strobes  (strobes),
    .slvReqS  (slvReqS),
    .slvRdS   (slvRdS),
    .slvWrS   (slvWrS),
    .ramRdN   (ramRdN),
    .ramWrN   (ramWrN),
    .slvXackN (slvXackN)
  );

  dpArbCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .slvReq  (slvReqS),
    .slvRd   (slvRdS),
    .slvWr   (slvWrS),
    .cpuReq  (!cpuReqN),
    .ramAack (!ramAackN),
    .strobes (strobes)
  );

  assign slaveModeN = ~strobes.slaveMode;
  assign offBdCsN   = ~strobes.chipSel;
endmodule

// File: tb/tb_dpRamArbiter.sv
`timescale 1ns/1ps
module tb_dpRamArbiter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slvReqN = 1'b1, slvRdN = 1'b1, slvWrN = 1'b1;
  logic cpuReqN = 1'b1, cpuRdN = 1'b1, cpuWrN = 1'b1;
  logic ramAackN = 1'b1, ramXackN = 1'b1;
  logic slaveModeN, offBdCsN, ramRdN, ramWrN, slvXackN;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dpRamArbiter dut (
    .clk(clk), .rstN(rstN), .slvReqN(slvReqN), .slvRdN(slvRdN), .slvWrN(slvWrN),
    .cpuReqN(cpuReqN), .cpuRdN(cpuRdN), .cpuWrN(cpuWrN),
    .ramAackN(ramAackN), .ramXackN(ramXackN),
    .slaveModeN(slaveModeN), .offBdCsN(offBdCsN), .ramRdN(ramRdN),
    .ramWrN(ramWrN), .slvXackN(slvXackN)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic lineOf(input bit wr);
    return wr ? ramWrN : ramRdN;
  endfunction

  task automatic slaveOn(input bit wr);
    slvReqN = 1'b0;
    if (wr) slvWrN = 1'b0; else slvRdN = 1'b0;
  endtask

  task automatic cpuDrive(input bit on, input bit wr);
    cpuReqN = !on;
    cpuRdN  = !(on && !wr);
    cpuWrN  = !(on && wr);
  endtask

  // Called at the negedge where the slave strobe is expected on the RAM line
  task automatic slaveTail(input bit wr, input bit cpuWaits, input bit cpuWr);
    chk("R3", "slave strobe", lineOf(wr), 1'b0);
    if (!(cpuWaits && cpuWr == !wr)) chk("R3", "other strobe", lineOf(!wr), 1'b1);
    ramAackN = 1'b0;
    step(2);
    ramXackN = 1'b0;
    step(1);
    chk("R5", "slvXackN low", slvXackN, 1'b0);
    slvRdN = 1'b1; slvWrN = 1'b1; ramAackN = 1'b1; ramXackN = 1'b1;
    step(1);
    chk("R5", "slvXackN released", slvXackN, 1'b1);
    slvReqN = 1'b1;
    step(2);
    chk("R6", "strobe off edge3", lineOf(wr), 1'b1);
    chk("R6", "slave mode kept edge3", slaveModeN, 1'b0);
    step(1);
    chk("R6", "slave mode off edge4", slaveModeN, 1'b1);
    chk("R6", "cs kept edge4", offBdCsN, 1'b0);
    if (cpuWaits) chk("R7", "cpu still held", lineOf(cpuWr), 1'b1);
    step(1);
    chk("R6", "cs off edge5", offBdCsN, 1'b1);
    if (cpuWaits) begin
      step(1);
      chk("R7", "cpu strobe after cs", lineOf(cpuWr), 1'b0);
      cpuDrive(1'b0, cpuWr);
      step(1);
    end
    step(2);
  endtask

  // Slave restart after a processor access ends; called at the negedge of the drop
  task automatic restartTail(input bit wr, input bit cpuWr);
    cpuDrive(1'b0, cpuWr);
    step(1);
    chk("R10", "cpu strobe off", lineOf(cpuWr), 1'b1);
    chk("R10", "slave mode not yet", slaveModeN, 1'b1);
    step(1);
    chk("R10", "slave mode restarted", slaveModeN, 1'b0);
    step(1);
    chk("R3", "cs after restart", offBdCsN, 1'b0);
    step(1);
    slaveTail(wr, 1'b0, cpuWr);
  endtask

  task automatic runScenario(input int sc, input bit wr, input bit cpuWr);
    step(1);
    case (sc)
      0: begin // plain slave cycle
        slaveOn(wr);
        step(3);
        chk("R2", "slave mode not at edge3", slaveModeN, 1'b1);
        step(1);
        chk("R2", "slave mode at edge4", slaveModeN, 1'b0);
        chk("R3", "cs not with mode", offBdCsN, 1'b1);
        step(1);
        chk("R3", "cs at edge5", offBdCsN, 1'b0);
        chk("R3", "strobe not yet", lineOf(wr), 1'b1);
        step(1);
        slaveTail(wr, 1'b0, cpuWr);
      end
      1: begin // R8 abort in the one-clock window
        slaveOn(wr);
        step(3);
        cpuDrive(1'b1, cpuWr);
        step(1);
        chk("R8", "cpu strobe passed", lineOf(cpuWr), 1'b0);
        chk("R8", "slave mode aborted", slaveModeN, 1'b1);
        for (int k = 0; k < 3; k++) begin
          step(1);
          chk("R8", "slave held off", slaveModeN, 1'b1);
        end
        restartTail(wr, cpuWr);
      end
      2: begin // R9 simultaneous, R11 xack ignored
        slaveOn(wr);
        cpuDrive(1'b1, cpuWr);
        step(1);
        chk("R9", "cpu strobe first", lineOf(cpuWr), 1'b0);
        ramXackN = 1'b0;
        for (int k = 0; k < 5; k++) begin
          step(1);
          chk("R9", "slave mode held off", slaveModeN, 1'b1);
          chk("R11", "xack ignored", slvXackN, 1'b1);
        end
        ramXackN = 1'b1;
        restartTail(wr, cpuWr);
      end
      default: begin // R7 committed cycle holds
        slaveOn(wr);
        step(4);
        chk("R2", "committed", slaveModeN, 1'b0);
        cpuDrive(1'b1, cpuWr);
        step(1);
        chk("R7", "mode kept", slaveModeN, 1'b0);
        if (cpuWr == wr) chk("R7", "cpu line idle", lineOf(cpuWr), 1'b1);
        else             chk("R7", "cpu line idle", lineOf(cpuWr), 1'b1);
        step(1);
        slaveTail(wr, 1'b1, cpuWr);
      end
    endcase
  endtask

  initial begin
    step(3);
    chk("R1", "slaveModeN in reset", slaveModeN, 1'b1);
    chk("R1", "offBdCsN in reset", offBdCsN, 1'b1);
    chk("R1", "ramRdN in reset", ramRdN, 1'b1);
    chk("R1", "ramWrN in reset", ramWrN, 1'b1);
    chk("R1", "slvXackN in reset", slvXackN, 1'b1);
    rstN = 1'b1;
    step(2);
    chk("R1", "slaveModeN after reset", slaveModeN, 1'b1);
    chk("R1", "ramRdN after reset", ramRdN, 1'b1);
    for (int sc = 0; sc < 4; sc++)
      for (int w = 0; w < 2; w++)
        for (int cw = 0; cw < 2; cw++)
          runScenario(sc, w[0], cw[0]);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule